// File: doc/BRIEF.md
# Synchronous Rectifier Gate Timing

This block drives the gates of the two synchronous rectifiers on the secondary side of a half-bridge resonant converter. The half-bridge generator supplies a strobe at the start of each switching cycle, a phase bit that tells which half of the cycle is running, and the current period in clock counts. One rectifier conducts in the negative half and the other in the positive half. Inside its own half, each gate switches on a programmable number of clocks after the half begins. It switches off a programmable number of clocks before the half would end.

A comparator-assisted mode can keep a gate on past its nominal turn-off point. This lasts while a per-rectifier current comparator, after synchronisation, still reports current above its threshold. The mode can only make the pulse later, never earlier, and the gate is always released by the end of its half. The comparator output comes from analog sensing outside this block. A separate enable forces both gates off.

Top module: `sr_gate_timing`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both gates are low.
- R2: `gate_neg` is high only during halves where `phase` was 1 (negative half), and `gate_pos` only during halves where `phase` was 0. The two gates are never high together.
- R3: A half begins on the clock edge where `cyc_start` is 1 or `phase` differs from its previous value. Counting that edge as position 0, a gate with rise margin `r` goes high at the edge of position `r+1`.
- R4: The half length is `floor(period/2)`. With fall margin `f`, the gate is last high at the edge of position `half-f`, so the pulse lasts `half-r-f` clocks.
- R5: When `r+f >= half`, that rectifier gives no pulse in the half. When `r+f = half-1`, it gives a single-clock pulse.
- R6: While `sr_enable` is 0, both gates go low one clock later, whatever the other inputs are.
- R7: In comparator mode, a gate that is on at its nominal turn-off point stays on while its synchronised comparator bit is 1. It drops at the first position where that bit is 0, and does not rise again in that half.
- R8: The comparator never advances turn-off. With comparator mode on and the comparator low, or with comparator mode off and the comparator high, the pulse matches R4 exactly.
- R9: In comparator mode the gate is low from position `half+1` on, even if the comparator stays high.
- R10: Each comparator bit passes through two flip-flops before it is used. A change at the input first affects the gate three clock edges later.
- R11: `period` and the four margins are captured only on edges where `cyc_start` is 1. Changes at any other time have no effect until the next cycle start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | One-clock strobe at the start of each switching cycle |
| phase | input | 1 | Current half of the cycle: 0 positive, 1 negative |
| period | input | CNT_W | Switching period in clocks, captured at cycle start |
| sr_enable | input | 1 | Enables both rectifier gates |
| cmp_mode | input | 1 | Allows comparators to extend the gate beyond its nominal turn-off point |
| rise_margin_neg | input | CNT_W-1 | Turn-on delay of the negative-half rectifier |
| fall_margin_neg | input | CNT_W-1 | Turn-off advance of the negative-half rectifier |
| rise_margin_pos | input | CNT_W-1 | Turn-on delay of the positive-half rectifier |
| fall_margin_pos | input | CNT_W-1 | Turn-off advance of the positive-half rectifier |
| cmp_above | input | 2 | Comparator bits, 1 = current above threshold; bit 0 negative-half rectifier, bit 1 positive |
| gate_neg | output | 1 | Gate of the rectifier conducting in the negative half |
| gate_pos | output | 1 | Gate of the rectifier conducting in the positive half |

## Verification
The bench aims at the boundary where the two margins add up to exactly the half length or one less. An off-by-one in the window test would show there as a stray one-clock pulse or a missing one. It also runs an odd period, where the negative half is one clock longer than the computed half. A design that used the phase bit rather than the half length to end the pulse would keep the gate on a clock too long. In comparator mode it holds the comparator high for the whole half, which a design without the end-of-half bound would never release. It also drops the comparator and raises it again after the drop, which catches a gate that turns back on. Margins changed in mid-cycle catch a design that reads them live instead of capturing them at cycle start.

// File: rtl/sr_gate_pkg.sv
package sr_gate_pkg;

    typedef enum logic {
        HALF_POS = 1'b0,
        HALF_NEG = 1'b1
    } half_e;

    localparam int unsigned NUM_RECT = 2;

    // Lane 0 conducts in the negative half, lane 1 in the positive half.
    function automatic half_e lane_half(input int unsigned idx);
        return (idx == 0) ? HALF_NEG : HALF_POS;
    endfunction

endpackage

// File: rtl/sr_cmp_sync.sv
module sr_cmp_sync #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = raw_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;

    // R10: first stage follows the raw input by one clock
    p_stage1_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> st_q.s1 == $past(raw_i));

    // R10: second stage follows the first by one clock
    p_stage2_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> sync_o == $past(st_q.s1));

endmodule

// File: rtl/sr_half_timer.sv
module sr_half_timer
    import sr_gate_pkg::*;
#(
    parameter int unsigned CNT_W = 12,
    localparam int unsigned MW   = CNT_W - 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cyc_start_i,
    input  logic                          phase_i,
    input  logic [CNT_W-1:0]              period_i,
    input  logic [NUM_RECT-1:0][MW-1:0]   rise_i,
    input  logic [NUM_RECT-1:0][MW-1:0]   fall_i,
    output logic [CNT_W-1:0]              pos_o,
    output half_e                         half_o,
    output logic [MW-1:0]                 half_len_o,
    output logic [NUM_RECT-1:0][MW-1:0]   rise_o,
    output logic [NUM_RECT-1:0][MW-1:0]   fall_o
);

    typedef struct packed {
        logic [CNT_W-1:0]            pos;
        half_e                       half;
        logic [MW-1:0]               half_len;
        logic [NUM_RECT-1:0][MW-1:0] rise;
        logic [NUM_RECT-1:0][MW-1:0] fall;
    } tmr_t;

    tmr_t  st_d, st_q;
    half_e half_in;
    logic  new_half;

    always_comb begin
        half_in  = half_e'(phase_i);
        new_half = cyc_start_i || (half_in != st_q.half);
        st_d     = st_q;
        if (new_half) begin
            st_d.pos = '0;
        end else if (st_q.pos != '1) begin
            st_d.pos = st_q.pos + 1'b1;
        end
        st_d.half = half_in;
        if (cyc_start_i) begin
            st_d.half_len = MW'(period_i >> 1);
            st_d.rise     = rise_i;
            st_d.fall     = fall_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{pos: '0, half: HALF_POS, half_len: '0, rise: '0, fall: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pos_o      = st_q.pos;
    assign half_o     = st_q.half;
    assign half_len_o = st_q.half_len;
    assign rise_o     = st_q.rise;
    assign fall_o     = st_q.fall;

    // R3: a cycle-start strobe restarts the position count
    p_start_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cyc_start_i) |-> pos_o == '0);

    // R11: captured settings hold between cycle starts
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cyc_start_i) |-> ($stable(half_len_o) && $stable(rise_o) && $stable(fall_o)));

endmodule

// File: rtl/sr_gate_lane.sv
module sr_gate_lane
    import sr_gate_pkg::*;
#(
    parameter int unsigned CNT_W     = 12,
    parameter half_e       LANE_HALF = HALF_POS,
    localparam int unsigned MW       = CNT_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] pos_i,
    input  half_e            half_i,
    input  logic [MW-1:0]    half_len_i,
    input  logic [MW-1:0]    rise_i,
    input  logic [MW-1:0]    fall_i,
    input  logic             cmp_i,
    input  logic             en_i,
    input  logic             cmp_mode_i,
    output logic             gate_o
);

    typedef struct packed {
        logic gate;
    } lane_t;

    lane_t st_d, st_q;

    logic [CNT_W-1:0] rise_w, fall_w, len_w, sum_w, off_w;
    logic own_half, window_ok, nominal, past_off, extend;

    always_comb begin
        rise_w    = CNT_W'(rise_i);
        fall_w    = CNT_W'(fall_i);
        len_w     = CNT_W'(half_len_i);
        sum_w     = rise_w + fall_w;
        off_w     = len_w - fall_w;
        own_half  = (half_i == LANE_HALF);
        window_ok = (sum_w < len_w);
        nominal   = (pos_i >= rise_w) && (pos_i < off_w);
        past_off  = (pos_i >= off_w) && (pos_i < len_w);
        extend    = cmp_mode_i && cmp_i && st_q.gate && past_off;
        st_d.gate = en_i && own_half && window_ok && (nominal || extend);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gate_o = st_q.gate;

    // R2, R9: a gate is only on inside its own half, before the half length
    p_in_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gate_o |-> $past(own_half && (pos_i < len_w)));

    // R5: no pulse from a window that the margins close
    p_short_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        gate_o |-> $past(window_ok));

    // R8: inside the nominal window an enabled gate is always on
    p_no_advance_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_i && own_half && window_ok && nominal) |-> gate_o);

    // R7: past the nominal point the gate stays on only on comparator demand
    p_ext_needs_cmp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_o && $past(past_off)) |-> $past(cmp_i && cmp_mode_i && gate_o));

    // R7: the gate never rises after the nominal turn-off point
    p_no_retrigger_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_o) |-> $past(nominal));

endmodule

// File: rtl/sr_gate_timing.sv
module sr_gate_timing
    import sr_gate_pkg::*;
#(
    parameter int unsigned CNT_W = 12,
    localparam int unsigned MW   = CNT_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_start,
    input  logic             phase,
    input  logic [CNT_W-1:0] period,
    input  logic             sr_enable,
    input  logic             cmp_mode,
    input  logic [MW-1:0]    rise_margin_neg,
    input  logic [MW-1:0]    fall_margin_neg,
    input  logic [MW-1:0]    rise_margin_pos,
    input  logic [MW-1:0]    fall_margin_pos,
    input  logic [1:0]       cmp_above,
    output logic             gate_neg,
    output logic             gate_pos
);

    logic [NUM_RECT-1:0][MW-1:0] rise_pk, fall_pk, rise_l, fall_l;
    logic [NUM_RECT-1:0]         cmp_s, gates;
    logic [CNT_W-1:0]            pos;
    half_e                       half;
    logic [MW-1:0]               half_len;

    assign rise_pk[0] = rise_margin_neg;
    assign fall_pk[0] = fall_margin_neg;
    assign rise_pk[1] = rise_margin_pos;
    assign fall_pk[1] = fall_margin_pos;

    sr_cmp_sync #(.W(NUM_RECT)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (cmp_above),
        .sync_o (cmp_s)
    );

    sr_half_timer #(.CNT_W(CNT_W)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_start_i (cyc_start),
        .phase_i     (phase),
        .period_i    (period),
        .rise_i      (rise_pk),
        .fall_i      (fall_pk),
        .pos_o       (pos),
        .half_o      (half),
        .half_len_o  (half_len),
        .rise_o      (rise_l),
        .fall_o      (fall_l)
    );

    for (genvar g = 0; g < NUM_RECT; g++) begin : g_lane
        sr_gate_lane #(
            .CNT_W     (CNT_W),
            .LANE_HALF (lane_half(g))
        ) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .pos_i      (pos),
            .half_i     (half),
            .half_len_i (half_len),
            .rise_i     (rise_l[g]),
            .fall_i     (fall_l[g]),
            .cmp_i      (cmp_s[g]),
            .en_i       (sr_enable),
            .cmp_mode_i (cmp_mode),
            .gate_o     (gates[g])
        );
    end

    assign gate_neg = gates[0];
    assign gate_pos = gates[1];

    // R2: the two rectifiers never conduct together
    p_mutex_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_neg && gate_pos));

    // R6: a low enable clears both gates on the next clock
    p_enable_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sr_enable) |-> (!gate_neg && !gate_pos));

    // R1: gates are low in the first cycle after reset
    p_reset_low_r1: assert property (@(posedge clk)
        !$past(rst_n) |-> (!gate_neg && !gate_pos));

endmodule

// File: tb/sim_sr_gate_timing.sv
module sim_sr_gate_timing;

    localparam int CW = 12;
    localparam int MW = CW - 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cyc_start, phase, sr_enable, cmp_mode;
    logic [CW-1:0] period;
    logic [MW-1:0] rise_margin_neg, fall_margin_neg, rise_margin_pos, fall_margin_pos;
    logic [1:0]    cmp_above;
    logic          gate_neg, gate_pos;

    always #5 clk = ~clk;

    sr_gate_timing #(.CNT_W(CW)) u0 (
        .clk (clk), .rst_n (rst_n), .cyc_start (cyc_start), .phase (phase),
        .period (period), .sr_enable (sr_enable), .cmp_mode (cmp_mode),
        .rise_margin_neg (rise_margin_neg), .fall_margin_neg (fall_margin_neg),
        .rise_margin_pos (rise_margin_pos), .fall_margin_pos (fall_margin_pos),
        .cmp_above (cmp_above), .gate_neg (gate_neg), .gate_pos (gate_pos)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string tag   = "R1";

    // stimulus settings
    int gen_per, per_next, gen_pos;
    int rise_v[2], fall_v[2], cmp_len[2], cmp_back[2];
    int en_v, cm_v;

    // reference model state
    int m_pos, m_half, m_len;
    int m_rise[2], m_fall[2], m_s1[2], m_s2[2], m_g[2];

    task automatic model_reset();
        m_pos = 0; m_half = 0; m_len = 0;
        for (int k = 0; k < 2; k++) begin
            m_rise[k] = 0; m_fall[k] = 0; m_s1[k] = 0; m_s2[k] = 0; m_g[k] = 0;
        end
    endtask

    task automatic model_step(input int cs, input int phs, input int per, input int c0, input int c1);
        int nx[2];
        for (int k = 0; k < 2; k++) begin
            int act, ok, off, nom, ext;
            act = (k == 0) ? (m_half == 1) : (m_half == 0);
            ok  = (m_rise[k] + m_fall[k]) < m_len;
            off = m_len - m_fall[k];
            nom = (m_pos >= m_rise[k]) && (m_pos < off);
            ext = cm_v && m_s2[k] && m_g[k] && (m_pos >= off) && (m_pos < m_len);
            nx[k] = (en_v && act && ok && (nom || ext)) ? 1 : 0;
        end
        m_s2[0] = m_s1[0]; m_s2[1] = m_s1[1];
        m_s1[0] = c0;      m_s1[1] = c1;
        if (cs || (phs != m_half)) m_pos = 0;
        else if (m_pos < (1 << CW) - 1) m_pos++;
        m_half = phs;
        if (cs) begin
            m_len = per / 2;
            for (int k = 0; k < 2; k++) begin
                m_rise[k] = rise_v[k]; m_fall[k] = fall_v[k];
            end
        end
        m_g[0] = nx[0]; m_g[1] = nx[1];
    endtask

    task automatic check_one(input string name, input logic act, input int exp);
        n_cmp++;
        if (act !== exp[0]) begin
            n_bad++;
            $display("FAIL %s %s at t=%0t actual=%0b expected=%0d", tag, name, $time, act, exp);
        end
    endtask

    task automatic check_outputs();
        check_one("gate_neg", gate_neg, m_g[0]);
        check_one("gate_pos", gate_pos, m_g[1]);
    endtask

    task automatic drive_and_step();
        int cs, phs, hp, pin, c0, c1;
        if (gen_pos == 0) gen_per = per_next;
        hp  = gen_per / 2;
        cs  = (gen_pos == 0);
        phs = (gen_pos >= hp);
        pin = phs ? gen_pos - hp : gen_pos;
        c0  = (phs  && (pin < cmp_len[0] || pin >= cmp_back[0])) ? 1 : 0;
        c1  = (!phs && (pin < cmp_len[1] || pin >= cmp_back[1])) ? 1 : 0;
        cyc_start       = cs[0];
        phase           = phs[0];
        period          = CW'(per_next);
        sr_enable       = en_v[0];
        cmp_mode        = cm_v[0];
        rise_margin_neg = MW'(rise_v[0]);
        fall_margin_neg = MW'(fall_v[0]);
        rise_margin_pos = MW'(rise_v[1]);
        fall_margin_pos = MW'(fall_v[1]);
        cmp_above       = {c1[0], c0[0]};
        model_step(cs, phs, gen_per, c0, c1);
        gen_pos = (gen_pos + 1) % gen_per;
    endtask

    task automatic run_cycles(input int n);
        repeat (n) begin
            check_outputs();
            drive_and_step();
            @(negedge clk);
        end
    endtask

    task automatic set_margins(input int r0, input int f0, input int r1, input int f1);
        rise_v[0] = r0; fall_v[0] = f0; rise_v[1] = r1; fall_v[1] = f1;
    endtask

    task automatic set_cmp(input int l0, input int b0, input int l1, input int b1);
        cmp_len[0] = l0; cmp_back[0] = b0; cmp_len[1] = l1; cmp_back[1] = b1;
    endtask

    initial begin
        rst_n = 1'b0; cyc_start = 0; phase = 0; period = '0; sr_enable = 0; cmp_mode = 0;
        rise_margin_neg = '0; fall_margin_neg = '0; rise_margin_pos = '0; fall_margin_pos = '0;
        cmp_above = '0;
        gen_per = 40; per_next = 40; gen_pos = 0; en_v = 0; cm_v = 0;
        set_margins(0, 0, 0, 0);
        set_cmp(0, 1 << 20, 0, 1 << 20);
        model_reset();
        repeat (3) @(negedge clk);
        tag = "R1";
        check_one("gate_neg in reset", gate_neg, 0);
        check_one("gate_pos in reset", gate_pos, 0);
        rst_n = 1'b1;

        // R1: first cycles after reset, enable still low
        run_cycles(4);

        // R6: enable low with live timing and comparator
        tag = "R6"; en_v = 0; set_margins(2, 2, 2, 2); set_cmp(30, 1 << 20, 30, 1 << 20);
        run_cycles(100);

        // R3 and R4: plain pulses, even period
        tag = "R3"; en_v = 1; set_cmp(0, 1 << 20, 0, 1 << 20); set_margins(3, 4, 0, 0);
        run_cycles(120);

        // R4: odd period, asymmetric margins
        tag = "R4"; per_next = 41; set_margins(1, 6, 5, 2);
        run_cycles(130);

        // R2: another mix, checks each gate stays in its own half
        tag = "R2"; per_next = 50; set_margins(7, 0, 0, 9);
        run_cycles(150);

        // R5: margins fill the half exactly, and one less
        tag = "R5"; per_next = 40; set_margins(10, 10, 9, 10);
        run_cycles(130);
        set_margins(19, 0, 0, 25);
        run_cycles(90);

        // R6: enable dropped in mid-pulse
        tag = "R6"; set_margins(2, 2, 2, 2);
        run_cycles(47);
        en_v = 0; run_cycles(13); en_v = 1; run_cycles(40);

        // R8: comparator mode with comparator low, then comparator high without the mode
        tag = "R8"; cm_v = 1; set_margins(2, 5, 3, 6); set_cmp(0, 1 << 20, 0, 1 << 20);
        run_cycles(100);
        cm_v = 0; set_cmp(100, 1 << 20, 100, 1 << 20);
        run_cycles(100);

        // R9: comparator high throughout: gate bounded by half length
        tag = "R9"; cm_v = 1; per_next = 41;
        run_cycles(130);

        // R7: comparator drops after the nominal point
        tag = "R7"; per_next = 40; set_margins(2, 8, 2, 8); set_cmp(15, 1 << 20, 14, 1 << 20);
        run_cycles(120);
        // R7: comparator returns after the drop; no second pulse
        set_cmp(14, 17, 13, 18);
        run_cycles(120);

        // R10: comparator drop just at the nominal point, latency visible
        tag = "R10"; set_margins(1, 6, 1, 6); set_cmp(12, 1 << 20, 13, 1 << 20);
        run_cycles(120);

        // R11: margins and period changed mid-cycle
        tag = "R11"; cm_v = 0; set_cmp(0, 1 << 20, 0, 1 << 20);
        run_cycles(25);
        set_margins(6, 1, 4, 3); per_next = 36;
        run_cycles(10);
        set_margins(0, 0, 1, 1);
        run_cycles(100);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL %s watchdog actual=running expected=finished", tag);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule